// File: doc/BRIEF.md
# PLL Frequency Change Sequencer

This block moves a clock-generating PLL from its present divider set (input divider M, feedback divider N, post divider code PL) to a new one, and also performs the PLL's wake-up and shut-down sequences. For a new divider set it picks one of two routes. If only N differs, it asks an external ramp controller to glide N smoothly. If M or PL differs, it first glides N down to the lowest legal VCO point, then stops, reprograms and relocks the PLL at that low N, and finally glides N up to the target. While the PLL is stopped, downstream logic is protected: the output VCO divider is switched to divide-by-2 and the clock mux is moved to bypass. The divider returns to divide-by-1 only after lock.

The low point is computed as `n_lo = ceil(M * MIN_VCO_KHZ / REF_KHZ)`. Timeouts work as follows:
- A glide that does not finish in time, or a lock that does not come, triggers one fallback. The fallback is a plain reprogram with the full target coefficients.
- A failure during the fallback ends the sequence with an error code.

Every wait is a parameter in microseconds and is scaled by `CYC_PER_US`.

States:
- `S_IDLE`: waits for a start request.
- `S_UP_WAKE`, `S_UP_W`, `S_UP_INIT`: power-up.
- `S_GLIDE`: glide request, waiting for done or for the timeout.
- Reprogram path: `S_RP_D2A`, `S_RP_D2B`, `S_RP_W1`, `S_RP_BYP`, `S_RP_DIS`, `S_RP_COEF`, `S_RP_EN`, `S_RP_LDET`, `S_RP_LOCK`, `S_RP_VCO`, `S_RP_W2`, `S_RP_D1A`, `S_RP_D1B`.
- Power-down path: `S_DN_BYP`, `S_DN_DIS`, `S_DN_IDDQ`.
- `S_FIN`: completion.

Transitions:
- `S_IDLE` to `S_UP_WAKE`, `S_GLIDE`, `S_RP_D2A`, `S_DN_BYP` or `S_FIN`.
- `S_GLIDE` to `S_RP_D2A` (glide-down done, or fallback), `S_DN_BYP` or `S_FIN`.
- `S_RP_LOCK` to `S_RP_VCO` (locked), to `S_RP_D2A` (fallback) or to `S_FIN` (failure).
- `S_RP_D1B` to `S_GLIDE` (glide up) or `S_FIN`.
- All other states advance in the order listed.

Top module: `pll_retune_seq`

## Requirements
- R1: On a power-up request, iddq falls first. At least 5 µs later a single output-divider write occurs (div_wr pulse) with out_mode=1, vco_div=0 and byp_div=0x3C. No glide and no enable change take place.
- R2: With the PLL enabled and the requested M and PL equal to coef_m and coef_pl, only one glide is requested, to the target N, and pll_en never toggles. If N is also equal, no glide is issued at all.
- R3: With the PLL enabled and M or PL changed, the first glide goes to n_lo of the current M. Then the PLL is re-enabled with the new M, the new PL and n_lo of the new M. A final glide goes to the target N.
- R4: Every reprogram writes vco_div code 2 (divide-by-2) on two consecutive cycles. sel_vco falls no earlier than 2 µs after the second of these writes.
- R5: sel_vco is low before pll_en falls. coef_m and coef_pl change only while pll_en and sel_vco are both low. pll_en is raised again after the coefficients are written.
- R6: After re-enabling, lock_det_off is driven low. sel_vco rises only after pll_lock has been seen. At least 2 µs later, vco_div code 0 (divide-by-1) is written on two consecutive cycles.
- R7: If pll_lock is missing for 300 µs, one fallback reprogram with the full target N follows. If that one also fails to lock, err=1, sel_vco stays low and the sequence ends.
- R8: If glide_done is missing for 500 µs during a retune, a fallback reprogram with the full target coefficients (N = target N) follows, with no later glide. err=2 after a successful fallback.
- R9: With the PLL disabled, a retune needs no glide down. It reprograms directly with n_lo of the new M and then glides up to the target N.
- R10: On a power-down request, an enabled PLL first glides to n_lo of coef_m. Then sel_vco falls, then pll_en falls, then iddq rises, each on a later cycle than the one before.
- R11: busy is high from the cycle after an accepted start until the one-cycle done pulse, which falls within busy. Start requests are ignored while busy. When several requests arrive together, power-up wins over power-down, and power-down wins over retune.
- R12: err reads 0 for success, 1 for lock failure and 2 for a glide timeout. It is cleared when the next sequence starts and does not change while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_up | input | 1 | Power-up request |
| start_down | input | 1 | Power-down request |
| start_prog | input | 1 | Retune request to tgt_m/tgt_n/tgt_pl |
| tgt_m | input | MW | Target input divider |
| tgt_n | input | NW | Target feedback divider |
| tgt_pl | input | PW | Target post divider code |
| pll_lock | input | 1 | Lock status from the PLL |
| glide_done | input | 1 | Ramp controller finished the glide |
| pll_en | output | 1 | PLL enable |
| lock_det_off | output | 1 | Lock detector disable |
| sel_vco | output | 1 | 1 selects the VCO output, 0 selects bypass |
| iddq | output | 1 | Low-power control |
| vco_div | output | 6 | Output VCO divider code (0 for /1, 2 for /2) |
| byp_div | output | 6 | Bypass divider code |
| out_mode | output | 1 | Output mode bit written at power-up |
| div_wr | output | 1 | Write strobe for the output divider fields |
| coef_m | output | MW | Programmed M |
| coef_n | output | NW | Programmed N, which is also the glide target |
| coef_pl | output | PW | Programmed PL |
| glide_req | output | 1 | Glide request to the ramp controller |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result code (see R12) |

## Verification
The retune function is exercised from several starting points:
- A cold PLL, which separates the direct reprogram path from the glide-down path.
- An N-only change and an unchanged request, which separate the pure glide from a no-op.
- An M and PL change, where the order of glide targets (old low N, new low N, target N) shows that the correct M feeds each n_lo.

Stalling the ramp model and the lock model separates the two fallback outcomes. The err value, the coefficients seen at each enable edge and the number of enable edges tell them apart. Simultaneous requests and a request made while busy check the priority and the rule that requests are ignored while busy.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_UP_WAKE, S_UP_W, S_UP_INIT, S_GLIDE,
        S_RP_D2A, S_RP_D2B, S_RP_W1, S_RP_BYP, S_RP_DIS, S_RP_COEF,
        S_RP_EN, S_RP_LDET, S_RP_LOCK, S_RP_VCO, S_RP_W2, S_RP_D1A, S_RP_D1B,
        S_DN_BYP, S_DN_DIS, S_DN_IDDQ, S_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        GP_DOWN, GP_UP, GP_ONLY, GP_PWRDN
    } glide_purpose_t;

    localparam logic [1:0] ERR_NONE  = 2'd0;
    localparam logic [1:0] ERR_LOCK  = 2'd1;
    localparam logic [1:0] ERR_GLIDE = 2'd2;

    localparam logic [5:0] DIVCODE_HALF = 6'd2;
    localparam logic [5:0] DIVCODE_ONE  = 6'd0;
    localparam logic [5:0] BYPCODE_INIT = 6'h3C;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= load_val;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/nlo_calc.sv
module nlo_calc #(
    parameter int MW          = 8,
    parameter int NW          = 8,
    parameter int REF_KHZ     = 12000,
    parameter int MIN_VCO_KHZ = 1000000
) (
    input  logic [MW-1:0] m,
    output logic [NW-1:0] n_lo
);
    localparam int PRW = MW + $clog2(MIN_VCO_KHZ + REF_KHZ + 1) + 1;
    localparam logic [PRW-1:0] NMAX = PRW'((1 << NW) - 1);

    logic [PRW-1:0] num;
    logic [PRW-1:0] quo;

    assign num  = PRW'(m) * PRW'(MIN_VCO_KHZ) + PRW'(REF_KHZ - 1);
    assign quo  = num / PRW'(REF_KHZ);
    assign n_lo = (quo > NMAX) ? NMAX[NW-1:0] : quo[NW-1:0];
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_seq_pkg::*;
#(
    parameter int MW          = 8,
    parameter int NW          = 8,
    parameter int PW          = 6,
    parameter int REF_KHZ     = 12000,
    parameter int MIN_VCO_KHZ = 1000000,
    parameter int CYC_PER_US  = 10,
    parameter int DIV_WAIT_US = 2,
    parameter int WAKE_US     = 5,
    parameter int LOCK_US     = 300,
    parameter int GLIDE_US    = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_up,
    input  logic          start_down,
    input  logic          start_prog,
    input  logic [MW-1:0] tgt_m,
    input  logic [NW-1:0] tgt_n,
    input  logic [PW-1:0] tgt_pl,
    input  logic          pll_lock,
    input  logic          glide_done,
    output logic          pll_en,
    output logic          lock_det_off,
    output logic          sel_vco,
    output logic          iddq,
    output logic [5:0]    vco_div,
    output logic [5:0]    byp_div,
    output logic          out_mode,
    output logic          div_wr,
    output logic [MW-1:0] coef_m,
    output logic [NW-1:0] coef_n,
    output logic [PW-1:0] coef_pl,
    output logic          glide_req,
    output logic          busy,
    output logic          done,
    output logic [1:0]    err
);
    localparam int DIV_C   = DIV_WAIT_US * CYC_PER_US;
    localparam int WAKE_C  = WAKE_US * CYC_PER_US;
    localparam int LOCK_C  = LOCK_US * CYC_PER_US;
    localparam int GLIDE_C = GLIDE_US * CYC_PER_US;
    localparam int TW      = $clog2(DIV_C + WAKE_C + LOCK_C + GLIDE_C + 1);

    seq_state_t     state, nxt;
    glide_purpose_t gp_q;
    logic           fb_q;
    logic [MW-1:0]  tm_q;
    logic [NW-1:0]  tn_q;
    logic [PW-1:0]  tp_q;
    logic [NW-1:0]  nlo_cur, nlo_new;
    logic           tmr_load, tmr_exp;
    logic [TW-1:0]  tmr_val;
    logic           same_mp;

    nlo_calc #(.MW(MW), .NW(NW), .REF_KHZ(REF_KHZ), .MIN_VCO_KHZ(MIN_VCO_KHZ))
        u_nlo_cur (.m(coef_m), .n_lo(nlo_cur));
    nlo_calc #(.MW(MW), .NW(NW), .REF_KHZ(REF_KHZ), .MIN_VCO_KHZ(MIN_VCO_KHZ))
        u_nlo_new (.m(tm_q), .n_lo(nlo_new));

    seq_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    assign same_mp   = pll_en && (tgt_m == coef_m) && (tgt_pl == coef_pl);
    assign glide_req = (state == S_GLIDE);
    assign busy      = (state != S_IDLE);
    assign done      = (state == S_FIN);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start_up)
                    nxt = S_UP_WAKE;
                else if (start_down)
                    nxt = (pll_en && nlo_cur != coef_n) ? S_GLIDE : S_DN_BYP;
                else if (start_prog) begin
                    if (same_mp)
                        nxt = (tgt_n != coef_n) ? S_GLIDE : S_FIN;
                    else if (pll_en && nlo_cur != coef_n)
                        nxt = S_GLIDE;
                    else
                        nxt = S_RP_D2A;
                end
            end
            S_UP_WAKE: nxt = S_UP_W;
            S_UP_W:    if (tmr_exp) nxt = S_UP_INIT;
            S_UP_INIT: nxt = S_FIN;
            S_GLIDE: begin
                if (glide_done)
                    nxt = (gp_q == GP_DOWN)  ? S_RP_D2A :
                          (gp_q == GP_PWRDN) ? S_DN_BYP : S_FIN;
                else if (tmr_exp)
                    nxt = (gp_q == GP_PWRDN) ? S_DN_BYP : S_RP_D2A;
            end
            S_RP_D2A:  nxt = S_RP_D2B;
            S_RP_D2B:  nxt = S_RP_W1;
            S_RP_W1:   if (tmr_exp) nxt = S_RP_BYP;
            S_RP_BYP:  nxt = S_RP_DIS;
            S_RP_DIS:  nxt = S_RP_COEF;
            S_RP_COEF: nxt = S_RP_EN;
            S_RP_EN:   nxt = S_RP_LDET;
            S_RP_LDET: nxt = S_RP_LOCK;
            S_RP_LOCK: begin
                if (pll_lock)     nxt = S_RP_VCO;
                else if (tmr_exp) nxt = fb_q ? S_FIN : S_RP_D2A;
            end
            S_RP_VCO:  nxt = S_RP_W2;
            S_RP_W2:   if (tmr_exp) nxt = S_RP_D1A;
            S_RP_D1A:  nxt = S_RP_D1B;
            S_RP_D1B:  nxt = (!fb_q && tn_q != coef_n) ? S_GLIDE : S_FIN;
            S_DN_BYP:  nxt = S_DN_DIS;
            S_DN_DIS:  nxt = S_DN_IDDQ;
            S_DN_IDDQ: nxt = S_FIN;
            S_FIN:     nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // wait windows are loaded on entry to a timed state
    assign tmr_load = (nxt != state);
    always_comb begin
        unique case (nxt)
            S_GLIDE:         tmr_val = TW'(GLIDE_C - 1);
            S_RP_LOCK:       tmr_val = TW'(LOCK_C - 1);
            S_RP_W1, S_RP_W2: tmr_val = TW'(DIV_C - 1);
            S_UP_W:          tmr_val = TW'(WAKE_C - 1);
            default:         tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // outputs and sequence registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_en <= 1'b0;  lock_det_off <= 1'b1;  sel_vco <= 1'b0;  iddq <= 1'b1;
            vco_div <= DIVCODE_ONE;  byp_div <= '0;  out_mode <= 1'b0;  div_wr <= 1'b0;
            coef_m <= MW'(1);  coef_n <= '0;  coef_pl <= '0;
            gp_q <= GP_DOWN;  fb_q <= 1'b0;  err <= ERR_NONE;
            tm_q <= '0;  tn_q <= '0;  tp_q <= '0;
        end else begin
            div_wr <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start_up || start_down || start_prog) begin
                        err <= ERR_NONE;  fb_q <= 1'b0;
                        tm_q <= tgt_m;  tn_q <= tgt_n;  tp_q <= tgt_pl;
                    end
                    if (nxt == S_GLIDE) begin
                        if (!start_down && same_mp) begin
                            gp_q <= GP_ONLY;  coef_n <= tgt_n;
                        end else begin
                            gp_q <= start_down ? GP_PWRDN : GP_DOWN;
                            coef_n <= nlo_cur;
                        end
                    end
                end
                S_UP_WAKE: iddq <= 1'b0;
                S_UP_INIT: begin
                    out_mode <= 1'b1;  vco_div <= DIVCODE_ONE;
                    byp_div <= BYPCODE_INIT;  div_wr <= 1'b1;
                end
                S_GLIDE: if (!glide_done && tmr_exp) begin
                    err <= ERR_GLIDE;
                    if (gp_q != GP_PWRDN) fb_q <= 1'b1;
                end
                S_RP_D2A, S_RP_D2B: begin vco_div <= DIVCODE_HALF; div_wr <= 1'b1; end
                S_RP_BYP:  sel_vco <= 1'b0;
                S_RP_DIS:  pll_en <= 1'b0;
                S_RP_COEF: begin
                    coef_m <= tm_q;  coef_pl <= tp_q;
                    coef_n <= fb_q ? tn_q : nlo_new;
                end
                S_RP_EN:   pll_en <= 1'b1;
                S_RP_LDET: lock_det_off <= 1'b0;
                S_RP_LOCK: if (!pll_lock && tmr_exp) begin
                    if (fb_q) err <= ERR_LOCK;
                    else      fb_q <= 1'b1;
                end
                S_RP_VCO:  sel_vco <= 1'b1;
                S_RP_D1A:  begin vco_div <= DIVCODE_ONE; div_wr <= 1'b1; end
                S_RP_D1B:  begin
                    vco_div <= DIVCODE_ONE;  div_wr <= 1'b1;
                    if (nxt == S_GLIDE) begin gp_q <= GP_UP; coef_n <= tn_q; end
                end
                S_DN_BYP:  sel_vco <= 1'b0;
                S_DN_DIS:  pll_en <= 1'b0;
                S_DN_IDDQ: iddq <= 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_div_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(div_wr) && vco_div == DIVCODE_HALF) |=> (div_wr && vco_div == DIVCODE_HALF));

    assert_bypass_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en) |-> !sel_vco);

    assert_coef_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({coef_m, coef_pl}) |-> (!pll_en && !sel_vco));

    assert_vco_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_vco) |-> $past(pll_lock, 2));

    assert_iddq_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iddq) |-> !pll_en);

    assert_err_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(err));
endmodule

// File: tb/sim_pll_retune_seq.sv
module sim_pll_retune_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CPU = 2;
    localparam int DIV_W = 2 * CPU;
    localparam int WAKE_W = 5 * CPU;

    logic clk = 0, rst_n = 0;
    logic start_up = 0, start_down = 0, start_prog = 0;
    logic [7:0] tgt_m = 0, tgt_n = 0;
    logic [5:0] tgt_pl = 0;
    logic pll_lock = 0, glide_done = 0;
    logic pll_en, lock_det_off, sel_vco, iddq, out_mode, div_wr, glide_req, busy, done;
    logic [5:0] vco_div, byp_div, coef_pl;
    logic [7:0] coef_m, coef_n;
    logic [1:0] err;

    pll_retune_seq #(.CYC_PER_US(CPU)) u0 (
        .clk(clk), .rst_n(rst_n), .start_up(start_up), .start_down(start_down),
        .start_prog(start_prog), .tgt_m(tgt_m), .tgt_n(tgt_n), .tgt_pl(tgt_pl),
        .pll_lock(pll_lock), .glide_done(glide_done), .pll_en(pll_en),
        .lock_det_off(lock_det_off), .sel_vco(sel_vco), .iddq(iddq), .vco_div(vco_div),
        .byp_div(byp_div), .out_mode(out_mode), .div_wr(div_wr), .coef_m(coef_m),
        .coef_n(coef_n), .coef_pl(coef_pl), .glide_req(glide_req), .busy(busy),
        .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit glide_stall = 0, lock_stall = 0, finished = 0;
    int gcnt = 0, lcnt = 0;
    int gl_log[8], gl_cnt;
    int dv_val[8], dv_cyc[8], dv_cnt;
    int en_m[4], en_n[4], en_cnt;
    int sel_fall, sel_rise, en_fall, iddq_fall, iddq_rise, start_cyc, done_cyc;
    logic p_sel = 0, p_en = 0, p_iddq = 1, p_gr = 0;

    function automatic int nlo(int m);
        return (m * 1000000 + 11999) / 12000;
    endfunction

    // ramp controller, PLL lock model and event monitor
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (glide_req) gcnt = gcnt + 1; else gcnt = 0;
        glide_done = (gcnt == 5) && !glide_stall;
        if (pll_en && !lock_det_off) lcnt = lcnt + 1; else lcnt = 0;
        pll_lock = (lcnt >= 6) && !lock_stall;
        if (glide_req && !p_gr && gl_cnt < 8) begin gl_log[gl_cnt] = coef_n; gl_cnt++; end
        if (div_wr && dv_cnt < 8) begin dv_val[dv_cnt] = vco_div; dv_cyc[dv_cnt] = cyc; dv_cnt++; end
        if (pll_en && !p_en && en_cnt < 4) begin en_m[en_cnt] = coef_m; en_n[en_cnt] = coef_n; en_cnt++; end
        if (!pll_en && p_en) en_fall = cyc;
        if (!sel_vco && p_sel) sel_fall = cyc;
        if (sel_vco && !p_sel) sel_rise = cyc;
        if (!iddq && p_iddq) iddq_fall = cyc;
        if (iddq && !p_iddq) iddq_rise = cyc;
        p_gr = glide_req; p_en = pll_en; p_sel = sel_vco; p_iddq = iddq;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        gl_cnt = 0; dv_cnt = 0; en_cnt = 0;
        sel_fall = -1; sel_rise = -1; en_fall = -1; iddq_fall = -1; iddq_rise = -1;
    endtask

    task automatic run(input bit up, input bit dn, input bit pg,
                       input int m, input int n, input int pl);
        clear_logs();
        @(negedge clk);
        tgt_m = 8'(m); tgt_n = 8'(n); tgt_pl = 6'(pl);
        start_up = up; start_down = dn; start_prog = pg;
        start_cyc = cyc;
        @(negedge clk);
        start_up = 0; start_down = 0; start_prog = 0;
    endtask

    task automatic wait_done(input string req);
        int k;
        k = 0;
        while (!done && k < 6000) begin @(negedge clk); k++; end
        chk(done == 1'b1, {req, " done within limit"}, done, 1);
        done_cyc = cyc;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, {req, " idle after done"}, busy, 0);
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0, "R11 reset busy", busy, 0);
        chk(iddq == 1 && pll_en == 0 && sel_vco == 0, "R12 reset controls", {iddq, pll_en, sel_vco}, 3'b100);
        chk(err == 0, "R12 reset err", err, 0);
    endtask

    task automatic t_powerup();
        run(1, 0, 0, 0, 0, 0);
        chk(busy == 1, "R11 busy during power-up", busy, 1);
        wait_done("R1");
        chk(iddq == 0, "R1 iddq cleared", iddq, 0);
        chk(dv_cnt == 1, "R1 one output write", dv_cnt, 1);
        chk(out_mode == 1 && byp_div == 6'h3C && vco_div == 0, "R1 output init", byp_div, 6'h3C);
        chk(dv_cyc[0] - iddq_fall >= WAKE_W, "R1 wake wait", dv_cyc[0] - iddq_fall, WAKE_W);
        chk(gl_cnt == 0 && en_cnt == 0, "R1 no glide or enable", gl_cnt + en_cnt, 0);
    endtask

    task automatic t_cold_prog();
        run(0, 0, 1, 1, 100, 2);
        wait_done("R9");
        chk(en_cnt == 1 && en_m[0] == 1 && en_n[0] == nlo(1), "R9 enable at low N", en_n[0], nlo(1));
        chk(gl_cnt == 1 && gl_log[0] == 100, "R9 single glide up", gl_log[0], 100);
        chk(dv_cnt == 4 && dv_val[0] == 2 && dv_val[1] == 2 && dv_cyc[1] == dv_cyc[0] + 1,
            "R4 div2 written twice", dv_val[1], 2);
        chk(dv_val[2] == 0 && dv_val[3] == 0 && dv_cyc[3] == dv_cyc[2] + 1, "R6 div1 written twice", dv_val[3], 0);
        chk(dv_cyc[2] - sel_rise >= DIV_W, "R6 wait after vco select", dv_cyc[2] - sel_rise, DIV_W);
        chk(sel_vco == 1 && pll_en == 1 && lock_det_off == 0, "R6 final controls", {sel_vco, pll_en, lock_det_off}, 3'b110);
        chk(coef_n == 100 && coef_m == 1 && coef_pl == 2 && err == 0, "R9 final coef", coef_n, 100);
    endtask

    task automatic t_same();
        run(0, 0, 1, 1, 120, 2);
        wait_done("R2");
        chk(gl_cnt == 1 && gl_log[0] == 120, "R2 glide only to target", gl_log[0], 120);
        chk(en_cnt == 0 && en_fall < 0, "R2 no enable change", en_cnt, 0);
        chk(coef_n == 120 && dv_cnt == 0, "R2 coef N updated", coef_n, 120);
    endtask

    task automatic t_change();
        run(0, 0, 1, 2, 200, 1);
        wait_done("R3");
        chk(gl_cnt == 2 && gl_log[0] == nlo(1), "R3 first glide to old low N", gl_log[0], nlo(1));
        chk(gl_log[1] == 200, "R3 glide up to target", gl_log[1], 200);
        chk(en_cnt == 1 && en_m[0] == 2 && en_n[0] == nlo(2), "R3 relock at new low N", en_n[0], nlo(2));
        chk(sel_fall - dv_cyc[1] >= DIV_W, "R4 wait before bypass", sel_fall - dv_cyc[1], DIV_W);
        chk(sel_fall < en_fall, "R5 bypass before disable", sel_fall, en_fall);
        chk(coef_m == 2 && coef_pl == 1 && coef_n == 200 && sel_vco == 1, "R3 final state", coef_n, 200);
    endtask

    task automatic t_glide_to();
        glide_stall = 1;
        run(0, 0, 1, 2, 180, 1);
        wait_done("R8");
        glide_stall = 0;
        chk(gl_cnt == 1, "R8 one glide attempted", gl_cnt, 1);
        chk(en_cnt == 1 && en_n[0] == 180, "R8 fallback uses full N", en_n[0], 180);
        chk(err == 2, "R8 err glide timeout", err, 2);
        chk(done_cyc - start_cyc >= 1000, "R8 timeout length", done_cyc - start_cyc, 1000);
        chk(coef_n == 180 && sel_vco == 1, "R8 final state", coef_n, 180);
    endtask

    task automatic t_priority();
        clear_logs();
        @(negedge clk);
        start_up = 1; start_prog = 1; start_down = 1; tgt_m = 3; tgt_n = 90; tgt_pl = 0;
        @(negedge clk);
        start_up = 0; start_prog = 0; start_down = 0;
        chk(err == 0, "R12 err cleared on start", err, 0);
        @(negedge clk);
        start_down = 1;
        @(negedge clk);
        start_down = 0;
        wait_done("R11");
        chk(gl_cnt == 0 && en_cnt == 0 && dv_cnt == 1, "R11 power-up wins", dv_cnt, 1);
        chk(pll_en == 1 && iddq == 0 && coef_m == 2, "R11 request while busy ignored", pll_en, 1);
        repeat (3) @(negedge clk);
        chk(err == 0 && busy == 0, "R12 err stable while idle", err, 0);
    endtask

    task automatic t_powerdown();
        run(0, 1, 0, 0, 0, 0);
        wait_done("R10");
        chk(gl_cnt == 1 && gl_log[0] == nlo(2), "R10 glide to low N", gl_log[0], nlo(2));
        chk(sel_fall > 0 && sel_fall < en_fall, "R10 bypass before disable", sel_fall, en_fall);
        chk(en_fall < iddq_rise, "R10 disable before iddq", en_fall, iddq_rise);
        chk(iddq == 1 && pll_en == 0 && sel_vco == 0, "R10 final controls", {iddq, pll_en, sel_vco}, 3'b100);
    endtask

    task automatic t_lock_to();
        lock_stall = 1;
        run(0, 0, 1, 3, 255, 2);
        wait_done("R7");
        lock_stall = 0;
        chk(en_cnt == 2 && en_n[0] == nlo(3) && en_n[1] == 255, "R7 fallback with full N", en_n[1], 255);
        chk(err == 1, "R7 err lock", err, 1);
        chk(sel_vco == 0 && gl_cnt == 0, "R7 stays in bypass", sel_vco, 0);
        chk(done_cyc - start_cyc >= 1200, "R7 two lock windows", done_cyc - start_cyc, 1200);
    endtask

    task automatic t_recover();
        run(0, 0, 1, 3, 255, 2);
        wait_done("R12");
        chk(err == 0 && gl_cnt == 0 && en_cnt == 0, "R2 unchanged request is a no-op", gl_cnt, 0);
        run(0, 0, 1, 1, 100, 2);
        wait_done("R3");
        chk(gl_cnt == 2 && gl_log[0] == nlo(3) && gl_log[1] == 100, "R3 glide order", gl_log[0], nlo(3));
        chk(en_cnt == 1 && en_n[0] == nlo(1) && err == 0 && sel_vco == 1, "R12 success code", err, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_powerup();
        t_cold_prog();
        t_same();
        t_change();
        t_glide_to();
        t_priority();
        t_powerdown();
        t_powerup();
        t_lock_to();
        t_recover();
        finish_run();
    end

    initial begin
        repeat (150000) @(negedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end
endmodule